// File: doc/BRIEF.md
# Configurable Register/Latch Macrocell

This block is one storage cell of a programmable-logic tile. It receives one product-term sum, one pin value, a small group of candidate clock signals, and the tile-wide asynchronous clear and set terms. Static configuration inputs select how the cell behaves:

- **Mode:** pass-through, D register, T register, or a latch that is transparent while its gate is low.
- **Clock:** which candidate drives the cell.
- **Polarity:** whether the result toward the pin is inverted.
- **Data source:** whether the cell captures the pin instead of the logic sum.

The cell drives two results. The pin-side result carries the selected polarity. The feedback result always carries the true stored or passed value, whatever the pin-side setting.

The cell is built for a single fast fabric clock `clk`. The candidate clocks are treated as level signals that are synchronous to `clk`. A rising edge is detected by comparing the selected level with its value one cycle earlier. The clear and set terms are sampled on every `clk` cycle, so they take effect whether or not the selected clock moves. Every result is registered and appears one `clk` cycle after the inputs that cause it. The synchronous reset `rst` returns every storage element to 0, which models power-up.

Top module: `pl_macrocell`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `fb_out`, `pin_out` and `err_out` are 0. The stored value is 0.
- R2: With `cfg_mode`=1 (D register), the stored value loads the data bit when the selected clock level goes from 0 to 1 between two `clk` cycles. It holds at all other times. A clock that is already high when `rst` falls is not counted as an edge.
- R3: With `cfg_mode`=2 (T register), a rising edge inverts the stored value when the data bit is 1. The value holds when the data bit is 0 and when there is no edge.
- R4: With `cfg_mode`=3 (latch), the stored value follows the data bit while the selected clock level is 0. It holds while that level is 1.
- R5: `cfg_clk_sel` is the index of the candidate clock in `clk_src` that the cell uses. Activity on every other candidate has no effect.
- R6: `pin_out` equals `fb_out` XOR `cfg_invert`. `cfg_invert`=1 presents the inverted result.
- R7: In the register modes, `bank_ar`=1 forces the stored value to 0 and `bank_ap`=1 forces it to 1. When both are 1, the result is 0. Either term overrides a coincident clock edge.
- R8: In latch mode with the gate level at 1 (closed), `bank_ar` forces 0 and `bank_ap` forces 1. When both are 1, the result is 0.
- R9: In latch mode with the gate level at 0 (open), a 1 on `bank_ar` or `bank_ap` is illegal. For that cycle, `err_out` rises to 1 and the stored value is forced to 0. `err_out` is 0 in any cycle with no such violation.
- R10: With `cfg_input_mode`=1, the cell stores `pin_in` and ignores `sop_in`. `cfg_mode`=3 selects a transparent-low input latch. Any other `cfg_mode` selects a D input register.
- R11: With `cfg_mode`=0 and `cfg_input_mode`=0, the storage is bypassed. `fb_out` is `sop_in` delayed by one cycle, the clear and set terms have no effect, and only the polarity is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset (power-up model) |
| clk_src | input | NUM_CLK | Candidate clock levels, synchronous to `clk` |
| cfg_mode | input | 2 | 0 pass-through, 1 D register, 2 T register, 3 transparent-low latch |
| cfg_clk_sel | input | SEL_W | Index of the candidate clock used by the cell |
| cfg_invert | input | 1 | 1 inverts the pin-side result |
| cfg_input_mode | input | 1 | 1 stores `pin_in` instead of `sop_in` |
| sop_in | input | 1 | Product-term sum (D or T data) |
| pin_in | input | 1 | Pin value for input-register/latch use |
| bank_ar | input | 1 | Tile-wide clear term |
| bank_ap | input | 1 | Tile-wide set term |
| pin_out | output | 1 | Cell result toward the pin path, polarity applied |
| fb_out | output | 1 | True cell result toward the interconnect |
| err_out | output | 1 | Illegal clear/set during an open latch gate |

## Verification
The bench targets the priority corners:

- **Simultaneous clear and set.** A design that let set win would show 1 in both register and closed-latch modes.
- **Clear or set with the latch gate open.** A missing error flag, or a stored 1, shows up on `err_out` and `fb_out`.
- **Edge detection across reset and clock reselection.** A spurious edge would load data with no real rising clock.
- **Clock index decoding.** Activity on an unselected candidate must leave the value unchanged.
- **Toggle with a data bit of 0.** A design that treated T as D would clear the value.
- **Input capture mode.** Data must come from the pin, not the sum. A swapped source shows up as wrong captured values.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_DREG  = 2'd1,
    MODE_TREG  = 2'd2,
    MODE_LATCH = 2'd3
  } mc_mode_e;

  typedef enum logic [1:0] {
    KIND_PASS  = 2'd0,
    KIND_REG   = 2'd1,
    KIND_LATCH = 2'd2
  } mc_kind_e;

  // Storage behaviour implied by mode and data source.
  function automatic mc_kind_e kind_of(input mc_mode_e mode, input logic in_mode);
    if (mode == MODE_LATCH)     return KIND_LATCH;
    else if (in_mode)           return KIND_REG;
    else if (mode == MODE_PASS) return KIND_PASS;
    else                        return KIND_REG;
  endfunction

endpackage

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int NUM_CLK = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLK-1:0] clk_src,
  input  logic [SEL_W-1:0]   sel,
  output logic               lvl,
  output logic               rise
);

  logic lvl_prev;

  generate
    if (NUM_CLK == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign lvl = clk_src[0];
    end else begin : g_mux
      always_comb begin
        lvl = 1'b0;
        for (int i = 0; i < NUM_CLK; i++) begin
          if (sel == SEL_W'(i)) lvl = clk_src[i];
        end
      end
    end
  endgenerate

  // Reset to 1 so a clock held high across reset is not seen as an edge.
  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b1;
    else     lvl_prev <= lvl;
  end

  assign rise = lvl & ~lvl_prev;

endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mc_kind_e kind,
  input  logic     toggle,
  input  logic     d,
  input  logic     gate,
  input  logic     rise,
  input  logic     ar,
  input  logic     ap,
  output logic     q_next,
  output logic     illegal
);

  logic q;

  always_comb begin
    q_next  = q;
    illegal = 1'b0;
    unique case (kind)
      KIND_REG: begin
        if (ar)        q_next = 1'b0;
        else if (ap)   q_next = 1'b1;
        else if (rise) q_next = toggle ? (q ^ d) : d;
      end
      KIND_LATCH: begin
        if (!gate) begin
          if (ar || ap) begin
            illegal = 1'b1;
            q_next  = 1'b0;
          end else begin
            q_next = d;
          end
        end else begin
          if (ar)      q_next = 1'b0;
          else if (ap) q_next = 1'b1;
        end
      end
      default: q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic invert,
  input  logic d,
  input  logic q_next,
  input  logic illegal,
  output logic pin_out,
  output logic fb_out,
  output logic err_out
);

  logic result;

  assign result = bypass ? d : q_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      fb_out  <= 1'b0;
      err_out <= 1'b0;
    end else begin
      pin_out <= result ^ invert;
      fb_out  <= result;
      err_out <= illegal;
    end
  end

endmodule

// File: rtl/pl_macrocell.sv
module pl_macrocell
  import mc_pkg::*;
#(
  parameter  int NUM_CLK = 4,
  localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CLK-1:0] clk_src,
  input  logic [1:0]         cfg_mode,
  input  logic [SEL_W-1:0]   cfg_clk_sel,
  input  logic               cfg_invert,
  input  logic               cfg_input_mode,
  input  logic               sop_in,
  input  logic               pin_in,
  input  logic               bank_ar,
  input  logic               bank_ap,
  output logic               pin_out,
  output logic               fb_out,
  output logic               err_out
);

  mc_mode_e mode;
  mc_kind_e kind;
  logic     data_bit;
  logic     toggle;
  logic     gate_lvl;
  logic     clk_rise;
  logic     q_next;
  logic     illegal;

  assign mode     = mc_mode_e'(cfg_mode);
  assign kind     = kind_of(mode, cfg_input_mode);
  assign data_bit = cfg_input_mode ? pin_in : sop_in;
  assign toggle   = (mode == MODE_TREG) && !cfg_input_mode;

  mc_clk_pick #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .clk_src (clk_src),
    .sel     (cfg_clk_sel),
    .lvl     (gate_lvl),
    .rise    (clk_rise)
  );

  mc_store u_store (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .toggle  (toggle),
    .d       (data_bit),
    .gate    (gate_lvl),
    .rise    (clk_rise),
    .ar      (bank_ar),
    .ap      (bank_ap),
    .q_next  (q_next),
    .illegal (illegal)
  );

  mc_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .bypass  (kind == KIND_PASS),
    .invert  (cfg_invert),
    .d       (data_bit),
    .q_next  (q_next),
    .illegal (illegal),
    .pin_out (pin_out),
    .fb_out  (fb_out),
    .err_out (err_out)
  );

endmodule

// File: rtl/pl_macrocell_chk.sv
module pl_macrocell_chk #(
  parameter  int NUM_CLK = 4,
  localparam int SEL_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CLK-1:0] clk_src,
  input logic [1:0]         cfg_mode,
  input logic [SEL_W-1:0]   cfg_clk_sel,
  input logic               cfg_invert,
  input logic               cfg_input_mode,
  input logic               sop_in,
  input logic               pin_in,
  input logic               bank_ar,
  input logic               bank_ap,
  input logic               pin_out,
  input logic               fb_out,
  input logic               err_out
);

  logic is_reg, is_latch, is_pass, gate;

  assign is_latch = (cfg_mode == 2'd3);
  assign is_pass  = (cfg_mode == 2'd0) && !cfg_input_mode;
  assign is_reg   = !is_latch && !is_pass;
  assign gate     = clk_src[cfg_clk_sel];

  logic unused_pin;
  assign unused_pin = pin_in;

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (is_reg && bank_ar) |=> !fb_out);

  p_set_alone_r7: assert property (@(posedge clk) disable iff (rst)
    (is_reg && bank_ap && !bank_ar) |=> fb_out);

  p_closed_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (is_latch && gate && bank_ar) |=> !fb_out);

  p_open_illegal_r9: assert property (@(posedge clk) disable iff (rst)
    (is_latch && !gate && (bank_ar || bank_ap)) |=> (err_out && !fb_out));

  p_err_only_latch_r9: assert property (@(posedge clk) disable iff (rst)
    (!is_latch) |=> !err_out);

  p_polarity_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out ^ fb_out) == $past(cfg_invert)));

  p_pass_r11: assert property (@(posedge clk) disable iff (rst)
    is_pass |=> (fb_out == $past(sop_in)));

  p_toggle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode == 2'd2) && !cfg_input_mode && !bank_ar && !bank_ap && !sop_in)
      |=> $stable(fb_out));

endmodule

bind pl_macrocell pl_macrocell_chk #(.NUM_CLK(NUM_CLK)) u_chk (
  .clk(clk), .rst(rst), .clk_src(clk_src), .cfg_mode(cfg_mode),
  .cfg_clk_sel(cfg_clk_sel), .cfg_invert(cfg_invert),
  .cfg_input_mode(cfg_input_mode), .sop_in(sop_in), .pin_in(pin_in),
  .bank_ar(bank_ar), .bank_ap(bank_ap), .pin_out(pin_out),
  .fb_out(fb_out), .err_out(err_out)
);

// File: tb/pl_macrocell_test.sv
`timescale 1ns/1ps
module pl_macrocell_test;

  localparam int NUM_CLK = 4;
  localparam int SEL_W   = 2;
  localparam int NV      = 34;

  logic clk = 1'b0;
  logic rst;
  logic [NUM_CLK-1:0] clk_src;
  logic [1:0] cfg_mode;
  logic [SEL_W-1:0] cfg_clk_sel;
  logic cfg_invert, cfg_input_mode, sop_in, pin_in, bank_ar, bank_ap;
  logic pin_out, fb_out, err_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pl_macrocell #(.NUM_CLK(NUM_CLK)) uut (
    .clk(clk), .rst(rst), .clk_src(clk_src), .cfg_mode(cfg_mode),
    .cfg_clk_sel(cfg_clk_sel), .cfg_invert(cfg_invert),
    .cfg_input_mode(cfg_input_mode), .sop_in(sop_in), .pin_in(pin_in),
    .bank_ar(bank_ar), .bank_ap(bank_ap), .pin_out(pin_out),
    .fb_out(fb_out), .err_out(err_out)
  );

  // {req[3:0], mode[1:0], sel[1:0], inv, inm, clk[3:0], sop, pin, ar, ap, efb, epin, eerr}
  function automatic logic [20:0] v(int req, int mode, int sel, bit inv, bit inm,
                                    logic [3:0] c, bit sop, bit pin, bit ar, bit ap,
                                    bit efb, bit epin, bit eerr);
    return {4'(req), 2'(mode), 2'(sel), inv, inm, c, sop, pin, ar, ap, efb, epin, eerr};
  endfunction

  localparam logic [20:0] TBL [NV] = '{
    v(2, 1,0,0,0,4'b0000,1,0,0,0, 0,0,0),  // R2 no edge
    v(2, 1,0,0,0,4'b0001,1,0,0,0, 1,1,0),  // R2 edge loads 1
    v(2, 1,0,0,0,4'b0001,0,0,0,0, 1,1,0),  // R2 high level holds
    v(2, 1,0,0,0,4'b0000,0,0,0,0, 1,1,0),  // R2 falling holds
    v(2, 1,0,0,0,4'b0001,0,0,0,0, 0,0,0),  // R2 edge loads 0
    v(2, 1,0,0,0,4'b0000,1,0,0,0, 0,0,0),
    v(5, 1,0,0,0,4'b0010,1,0,0,0, 0,0,0),  // R5 unselected clock
    v(5, 1,1,0,0,4'b0010,1,0,0,0, 1,1,0),  // R5 select index 1
    v(6, 1,1,1,0,4'b0000,0,0,0,0, 1,0,0),  // R6 inverted pin
    v(3, 2,1,0,0,4'b0010,1,0,0,0, 0,0,0),  // R3 toggle
    v(3, 2,1,0,0,4'b0000,1,0,0,0, 0,0,0),
    v(3, 2,1,0,0,4'b0010,1,0,0,0, 1,1,0),  // R3 toggle back
    v(3, 2,1,0,0,4'b0000,0,0,0,0, 1,1,0),
    v(3, 2,1,0,0,4'b0010,0,0,0,0, 1,1,0),  // R3 edge with T=0 holds
    v(7, 2,1,0,0,4'b0010,1,0,1,1, 0,0,0),  // R7 both -> 0
    v(7, 2,1,0,0,4'b0000,0,0,0,1, 1,1,0),  // R7 set
    v(7, 1,1,0,0,4'b0010,0,0,1,0, 0,0,0),  // R7 clear beats edge
    v(4, 3,1,0,0,4'b0000,1,0,0,0, 1,1,0),  // R4 open follows
    v(4, 3,1,0,0,4'b0000,0,0,0,0, 0,0,0),
    v(4, 3,1,0,0,4'b0000,1,0,0,0, 1,1,0),
    v(4, 3,1,0,0,4'b0010,0,0,0,0, 1,1,0),  // R4 closed holds
    v(8, 3,1,0,0,4'b0010,0,0,1,1, 0,0,0),  // R8 both closed -> 0
    v(8, 3,1,0,0,4'b0010,0,0,0,1, 1,1,0),  // R8 set closed
    v(8, 3,1,0,0,4'b0010,1,0,0,0, 1,1,0),
    v(9, 3,1,0,0,4'b0000,1,0,0,1, 0,0,1),  // R9 illegal open
    v(9, 3,1,0,0,4'b0000,1,0,0,0, 1,1,0),
    v(11,0,1,1,0,4'b0000,0,0,0,0, 0,1,0),  // R11 pass inverted
    v(11,0,1,0,0,4'b0000,1,0,1,0, 1,1,0),  // R11 clear ignored
    v(10,1,0,0,1,4'b0000,1,0,0,0, 1,1,0),  // R10 stored value held
    v(10,1,0,0,1,4'b0001,1,0,0,0, 0,0,0),  // R10 pin captured, sum ignored
    v(10,1,0,0,1,4'b0000,0,1,0,0, 0,0,0),
    v(10,1,0,0,1,4'b0001,0,1,0,0, 1,1,0),
    v(10,3,0,0,1,4'b0000,1,0,0,0, 0,0,0),  // R10 input latch open
    v(10,3,0,0,1,4'b0001,0,1,0,0, 0,0,0)   // R10 input latch closed
  };

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic drive(int mode, int sel, bit inv, bit inm, logic [3:0] c,
                       bit sop, bit pin, bit ar, bit ap);
    cfg_mode = 2'(mode); cfg_clk_sel = 2'(sel); cfg_invert = inv;
    cfg_input_mode = inm; clk_src = c; sop_in = sop; pin_in = pin;
    bank_ar = ar; bank_ap = ap;
  endtask

  task automatic step_chk(string tag, bit efb, bit epin, bit eerr);
    @(posedge clk); #1;
    chk(tag, "fb_out", fb_out, efb);
    chk(tag, "pin_out", pin_out, epin);
    chk(tag, "err_out", err_out, eerr);
  endtask

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0, 4'b0000, 0, 0, 0, 0);
    @(posedge clk); @(posedge clk); #1;
    chk("R1", "fb_out", fb_out, 1'b0);
    chk("R1", "pin_out", pin_out, 1'b0);
    chk("R1", "err_out", err_out, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [20:0] e;
      string tag;
      e = TBL[i];
      tag = $sformatf("R%0d vec%0d", e[20:17], i);
      drive(e[16:15], e[14:13], e[12], e[11], e[10:7], e[6], e[5], e[4], e[3]);
      step_chk(tag, e[2], e[1], e[0]);
    end

    // R1: reset clears a stored 1; a clock held high across reset is no edge (R2)
    drive(1, 0, 1, 0, 4'b0000, 1, 0, 0, 0);
    step_chk("R2 pre", 1'b0, 1'b1, 1'b0);
    drive(1, 0, 1, 0, 4'b0001, 1, 0, 0, 0);
    step_chk("R2 load", 1'b1, 1'b0, 1'b0);
    rst = 1'b1;
    step_chk("R1 in reset", 1'b0, 1'b0, 1'b0);
    step_chk("R1 in reset 2", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    step_chk("R2 no edge after reset", 1'b0, 1'b1, 1'b0);

    // R5: highest index selected, other candidates ignored
    drive(1, 3, 0, 0, 4'b0111, 1, 0, 0, 0);
    step_chk("R5 others toggling", 1'b0, 1'b0, 1'b0);
    drive(1, 3, 0, 0, 4'b0000, 1, 0, 0, 0);
    step_chk("R5 idle", 1'b0, 1'b0, 1'b0);
    drive(1, 3, 0, 0, 4'b1000, 1, 0, 0, 0);
    step_chk("R5 index 3 edge", 1'b1, 1'b1, 1'b0);

    // R9: both terms on an open latch, error lasts one cycle
    drive(3, 0, 0, 0, 4'b0000, 1, 0, 1, 1);
    step_chk("R9 both open", 1'b0, 1'b0, 1'b1);
    drive(3, 0, 0, 0, 4'b0000, 1, 0, 0, 0);
    step_chk("R9 cleared", 1'b1, 1'b1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule